// File: doc/BRIEF.md
# Audio Serial Bit and Word Clock Generator

This block builds the two timing clocks of an I2S audio link from a master clock that arrives at its input. The serial bit clock is the master clock divided by 2 or 4. The word-select clock, which marks left and right channel slots, is the bit clock divided by 32, 64 or 128. The block keeps one 32-bit control word, written through a simple write strobe. That word turns generation on and off, picks both ratios, picks which bit-clock edge the word clock moves on, and chooses whether its own settings or a configuration word on an input port are in effect.

All logic runs on the master clock, and both clocks leave the block as registered outputs. A new ratio or alignment choice does not cut a frame short. It is staged and applied only at the end of the current word-clock period. When generation is switched on, both dividers start from zero. The word clock therefore begins low and its first rise falls exactly on a bit-clock edge. An invalid word-clock ratio code is refused: the last valid ratio stays in use and an error flag is raised.

Top module: `i2s_clkgen`

## Requirements
- R1: While reset is asserted, `sclk`, `lrclk`, `cfgFromReg` and `ratioErr` are all low.
- R2: When the effective enable bit (bit 31) is clear, `sclk` and `lrclk` are held low from the second master-clock edge onward.
- R3: `sclk` has a 50% duty cycle. Each half period lasts 1 master-clock cycle when bit 16 of the effective word is 0 (divide by 2) and 2 cycles when it is 1 (divide by 4).
- R4: `lrclk` has a 50% duty cycle. Each half period spans 16, 32 or 64 aligned `sclk` edges for ratio code 0, 1 or 2 in bits 18:17, which is a full period of 32, 64 or 128 bit clocks.
- R5: With bit 19 clear, every `lrclk` transition happens in the same cycle as a rising `sclk` edge. With bit 19 set, it happens with a falling `sclk` edge.
- R6: When control-word bit 29 is set, the register settings are in effect. When it is clear, `defaultCfg` (same bit layout) is in effect and register bits other than 29 have no effect. `cfgFromReg` shows the value of bit 29.
- R7: When the effective ratio code is 3, the last valid word-clock ratio stays in use and `ratioErr` goes high one cycle later. `ratioErr` drops one cycle after a valid code is in effect again.
- R8: When the effective enable goes from clear to set, both dividers restart from zero. `lrclk` starts low and rises on exactly the 16th, 32nd or 64th aligned `sclk` edge after the enable.
- R9: A change to the bit-clock ratio, the word-clock ratio or the alignment edge made while the clocks are running takes effect only at the next falling edge of `lrclk`, the frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; every register runs on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Write strobe for the control word |
| cfgWdata | input | 32 | Control word value written when `cfgWe` is high |
| defaultCfg | input | 32 | Configuration in effect when control bit 29 is clear |
| sclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Left/right word clock |
| cfgFromReg | output | 1 | High when the register settings are in effect |
| ratioErr | output | 1 | High while an invalid word-clock ratio code is in effect |

## Verification
A corrupted bit-clock counter shows up at once as a stretched or shortened `sclk` half period, so the bench measures every half period in master-clock cycles. A slipped word-clock counter or a wrongly latched ratio first appears at the next `lrclk` transition. The bench therefore counts aligned bit-clock edges across successive word-clock halves, including the halves just before and just after a frame boundary. That count catches ratio changes applied too early and any edge misalignment within one frame. A staging register that accepts code 3 would change the next frame's length and would leave `ratioErr` low one cycle after the write.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;

  localparam int CFG_W        = 32;
  localparam int BIT_ENABLE   = 31;
  localparam int BIT_USE_REG  = 29;
  localparam int BIT_FALL     = 19;
  localparam int LR_SEL_LSB   = 17;
  localparam int BIT_SDIV_HI  = 16;
  localparam int LR_SEL_W     = 2;
  localparam logic [LR_SEL_W-1:0] LR_SEL_BAD = 2'd3;

  // Strobes and active settings passed from the control to the datapath
  typedef struct packed {
    logic                run;       // effective enable
    logic                restart;   // first enabled cycle: zero both dividers
    logic                sdivHi;    // bit clock = master / 4 when set
    logic [LR_SEL_W-1:0] lrSel;     // active word-clock ratio code
    logic                fallAlign; // word clock moves on falling bit-clock edge
  } clkCmd_t;

endpackage

// File: rtl/i2s_clkgen_ctrl.sv
module i2s_clkgen_ctrl
  import i2s_clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic [CFG_W-1:0] defaultCfg,
  input  logic             frameEnd,
  output clkCmd_t          cmd,
  output logic             cfgFromReg,
  output logic             ratioErr
);

  logic [CFG_W-1:0]    cfgReg;
  logic [CFG_W-1:0]    effCfg;
  logic                effEn;
  logic [LR_SEL_W-1:0] effLr;
  logic [LR_SEL_W-1:0] lastValidLr;
  logic [LR_SEL_W-1:0] candLr;
  logic                running;
  logic                restart;
  logic                activeSdiv;
  logic [LR_SEL_W-1:0] activeLr;
  logic                activePol;
  logic                loadActive;

  // Control word register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgReg <= '0;
    else if (cfgWe) cfgReg <= cfgWdata;
  end

  // Choose between the register and the default port
  always_comb begin
    effCfg  = cfgReg[BIT_USE_REG] ? cfgReg : defaultCfg;
    effEn   = effCfg[BIT_ENABLE];
    effLr   = effCfg[LR_SEL_LSB +: LR_SEL_W];
    candLr  = (effLr == LR_SEL_BAD) ? lastValidLr : effLr;
    restart = effEn && !running;
    loadActive = restart || frameEnd;
  end

  // Track the last valid ratio, the run state and the error flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastValidLr <= '0;
      running     <= 1'b0;
      ratioErr    <= 1'b0;
    end else begin
      lastValidLr <= candLr;
      running     <= effEn;
      ratioErr    <= (effLr == LR_SEL_BAD);
    end
  end

  // Settings become active only at restart or at a frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeSdiv <= 1'b0;
      activeLr   <= '0;
      activePol  <= 1'b0;
    end else if (loadActive) begin
      activeSdiv <= effCfg[BIT_SDIV_HI];
      activeLr   <= candLr;
      activePol  <= effCfg[BIT_FALL];
    end
  end

  always_comb begin
    cmd.run       = effEn;
    cmd.restart   = restart;
    cmd.sdivHi    = activeSdiv;
    cmd.lrSel     = activeLr;
    cmd.fallAlign = activePol;
    cfgFromReg    = cfgReg[BIT_USE_REG];
  end

  // An invalid ratio code is flagged on the following cycle
  assert_err_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (effLr == LR_SEL_BAD) |=> ratioErr);

  // Running settings stay frozen between frame boundaries
  assert_hold_mid_frame_R9: assert property (@(posedge clk) disable iff (!rstN)
    (running && effEn && !frameEnd) |=>
      ($stable(activeLr) && $stable(activeSdiv) && $stable(activePol)));

endmodule

// File: rtl/i2s_clkgen_dp.sv
module i2s_clkgen_dp
  import i2s_clkgen_pkg::*;
#(
  parameter int SCLK_DIV_LO = 2,
  parameter int SCLK_DIV_HI = 4,
  parameter int LR_BASE     = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  clkCmd_t cmd,
  output logic    sclk,
  output logic    lrclk,
  output logic    frameEnd
);

  localparam int SC_W       = $clog2(SCLK_DIV_HI);
  localparam int LC_W       = $clog2(LR_BASE * 2);
  localparam int LR_CODES   = 3;

  logic [SC_W-1:0] sCnt;
  logic [SC_W-1:0] sHalfLast;
  logic [LC_W-1:0] lrCnt;
  logic [LC_W-1:0] lrHalfLast;
  logic [LC_W-1:0] lrLastTbl [LR_CODES];
  logic            sclkQ;
  logic            lrclkQ;
  logic            sEdge;
  logic            alignEdge;
  logic            lrWrap;
  logic            active;

  // Half-period limits of the word clock, one for each valid code
  for (genvar k = 0; k < LR_CODES; k++) begin : gLrTbl
    assign lrLastTbl[k] = LC_W'(((LR_BASE / 2) << k) - 1);
  end

  always_comb begin
    sHalfLast  = cmd.sdivHi ? SC_W'(SCLK_DIV_HI / 2 - 1) : SC_W'(SCLK_DIV_LO / 2 - 1);
    case (cmd.lrSel)
      2'd1:    lrHalfLast = lrLastTbl[1];
      2'd2:    lrHalfLast = lrLastTbl[2];
      default: lrHalfLast = lrLastTbl[0];
    endcase
    active    = cmd.run && !cmd.restart;
    sEdge     = (sCnt == sHalfLast);
    alignEdge = sEdge && (cmd.fallAlign ? sclkQ : !sclkQ);
    lrWrap    = alignEdge && (lrCnt == lrHalfLast);
    frameEnd  = active && lrWrap && lrclkQ;
  end

  // Bit-clock divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sCnt  <= '0;
      sclkQ <= 1'b0;
    end else if (!active) begin
      sCnt  <= '0;
      sclkQ <= 1'b0;
    end else if (sEdge) begin
      sCnt  <= '0;
      sclkQ <= !sclkQ;
    end else begin
      sCnt  <= sCnt + 1'b1;
    end
  end

  // Word-clock divider, counting aligned bit-clock edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lrCnt  <= '0;
      lrclkQ <= 1'b0;
    end else if (!active) begin
      lrCnt  <= '0;
      lrclkQ <= 1'b0;
    end else if (lrWrap) begin
      lrCnt  <= '0;
      lrclkQ <= !lrclkQ;
    end else if (alignEdge) begin
      lrCnt  <= lrCnt + 1'b1;
    end
  end

  assign sclk  = sclkQ;
  assign lrclk = lrclkQ;

  // Disabled generator drives both clocks low
  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.run |=> (!sclkQ && !lrclkQ));

  // Word clock moves only together with a bit-clock edge
  assert_lr_on_sclk_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lrclkQ != $past(lrclkQ)) |-> (sclkQ != $past(sclkQ)));

  // Bit-clock counter never passes its half-period limit
  assert_scnt_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    sCnt <= sHalfLast);

  // Word-clock counter never passes its half-period limit
  assert_lrcnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    lrCnt <= lrHalfLast);

endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
  import i2s_clkgen_pkg::*;
#(
  parameter int SCLK_DIV_LO = 2,
  parameter int SCLK_DIV_HI = 4,
  parameter int LR_BASE     = 32
) (
  input  logic        mclk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [31:0] cfgWdata,
  input  logic [31:0] defaultCfg,
  output logic        sclk,
  output logic        lrclk,
  output logic        cfgFromReg,
  output logic        ratioErr
);

  clkCmd_t cmd;
  logic    frameEnd;

  i2s_clkgen_ctrl uCtrl (
    .clk        (mclk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgWdata   (cfgWdata),
    .defaultCfg (defaultCfg),
    .frameEnd   (frameEnd),
    .cmd        (cmd),
    .cfgFromReg (cfgFromReg),
    .ratioErr   (ratioErr)
  );

  i2s_clkgen_dp #(
    .SCLK_DIV_LO (SCLK_DIV_LO),
    .SCLK_DIV_HI (SCLK_DIV_HI),
    .LR_BASE     (LR_BASE)
  ) uDp (
    .clk      (mclk),
    .rstN     (rstN),
    .cmd      (cmd),
    .sclk     (sclk),
    .lrclk    (lrclk),
    .frameEnd (frameEnd)
  );

  // Reset leaves every output low
  assert_reset_low_R1: assert property (@(posedge mclk)
    !rstN |-> (!sclk && !lrclk && !ratioErr && !cfgFromReg));

endmodule

// File: tb/i2s_clkgen_test.sv
module i2s_clkgen_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] C_EN   = 32'h8000_0000;
  localparam logic [31:0] C_REG  = 32'h2000_0000;
  localparam logic [31:0] C_FALL = 32'h0008_0000;
  localparam logic [31:0] C_DIV4 = 32'h0001_0000;

  logic        mclk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] defaultCfg = '0;
  logic        sclk, lrclk, cfgFromReg, ratioErr;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;
  logic prevS, prevL, curS, curL;

  i2s_clkgen uut (
    .mclk(mclk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .defaultCfg(defaultCfg), .sclk(sclk), .lrclk(lrclk),
    .cfgFromReg(cfgFromReg), .ratioErr(ratioErr)
  );

  always #(CLK_PERIOD / 2) mclk = !mclk;

  function automatic logic [31:0] lrCode(input int code);
    return 32'(code) << 17;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [31:0] v);
    @(negedge mclk);
    cfgWe = 1'b1; cfgWdata = v;
    @(negedge mclk);
    cfgWe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge mclk);
  endtask

  task automatic step();
    prevS = curS; prevL = curL;
    @(negedge mclk);
    curS = sclk; curL = lrclk;
  endtask

  // Length of one sclk half period in master cycles
  task automatic sclkHalf(output int len);
    int guard;
    curS = sclk; curL = lrclk;
    guard = 0;
    do begin step(); guard++; end while (curS == prevS && guard < 100);
    len = 0;
    do begin step(); len++; end while (curS == prevS && len < 100);
  endtask

  // Aligned sclk edges up to and including the next lrclk change
  task automatic edgesToLr(input bit fall, output int n, output bit alignOk);
    bit edgeNow;
    n = 0; alignOk = 1'b1;
    curS = sclk; curL = lrclk;
    for (int i = 0; i < 4000; i++) begin
      step();
      edgeNow = (curS != prevS) && (curS == !fall);
      if (edgeNow) n++;
      if (curL != prevL) begin
        if (!edgeNow) alignOk = 1'b0;
        break;
      end
    end
  endtask

  task automatic testReset();
    idle(3);
    check(!sclk && !lrclk && !cfgFromReg && !ratioErr, "R1 reset outputs", {sclk, lrclk, cfgFromReg, ratioErr}, 0);
    rstN = 1'b1;
  endtask

  task automatic testDisabled();
    int seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge mclk);
      if (sclk || lrclk) seen++;
    end
    check(seen == 0, "R2 idle when disabled", seen, 0);
  endtask

  task automatic testStartRising();
    int n, h; bit ok;
    writeCfg(C_EN | C_REG | lrCode(0));
    check(cfgFromReg == 1'b1, "R6 register selected flag", cfgFromReg, 1);
    edgesToLr(1'b0, n, ok);
    check(n == 16, "R8 first lrclk rise after enable", n, 16);
    edgesToLr(1'b0, n, ok);
    check(n == 16 && ok, "R4 high half code 0", n, 16);
    check(ok, "R5 rising alignment", ok, 1);
    edgesToLr(1'b0, n, ok);
    check(n == 16 && ok, "R4 low half code 0", n, 16);
    sclkHalf(h);
    check(h == 1, "R3 sclk half divide 2", h, 1);
  endtask

  task automatic testFallDiv4();
    int n, h; bit ok;
    writeCfg(C_REG);
    idle(5);
    writeCfg(C_EN | C_REG | C_FALL | C_DIV4 | lrCode(1));
    sclkHalf(h);
    check(h == 2, "R3 sclk half divide 4", h, 2);
    edgesToLr(1'b1, n, ok);
    edgesToLr(1'b1, n, ok);
    check(n == 32, "R4 half code 1", n, 32);
    check(ok, "R5 falling alignment", ok, 1);
  endtask

  task automatic testBadCodeAndBoundary();
    int n; bit ok;
    writeCfg(C_REG);
    idle(5);
    writeCfg(C_EN | C_REG | lrCode(2));
    idle(1);
    check(!ratioErr, "R7 no error for valid code", ratioErr, 0);
    writeCfg(C_EN | C_REG | lrCode(3));
    idle(1);
    check(ratioErr, "R7 error for code 3", ratioErr, 1);
    edgesToLr(1'b0, n, ok);
    edgesToLr(1'b0, n, ok);
    check(n == 64, "R7 ratio kept after code 3", n, 64);
    edgesToLr(1'b0, n, ok);
    check(n == 64, "R7 ratio kept next half", n, 64);
    // now in a low half: change to code 0 mid-frame
    while (lrclk) @(negedge mclk);
    writeCfg(C_EN | C_REG | lrCode(0));
    idle(1);
    check(!ratioErr, "R7 error clears", ratioErr, 1'b0);
    edgesToLr(1'b0, n, ok);   // end of old low half
    edgesToLr(1'b0, n, ok);   // old high half
    check(n == 64, "R9 old ratio until boundary", n, 64);
    edgesToLr(1'b0, n, ok);
    check(n == 16, "R9 new ratio after boundary", n, 16);
  endtask

  task automatic testStopRunning();
    int seen = 0;
    writeCfg(C_REG | lrCode(0));
    idle(1);
    for (int i = 0; i < 100; i++) begin
      @(negedge mclk);
      if (sclk || lrclk) seen++;
    end
    check(seen == 0, "R2 outputs low after disable", seen, 0);
  endtask

  task automatic testDefaultPath();
    int h, seen;
    defaultCfg = C_EN | C_DIV4 | lrCode(0);
    writeCfg(C_EN | lrCode(1));   // register enable ignored, default in use
    check(cfgFromReg == 1'b0, "R6 default selected flag", cfgFromReg, 0);
    sclkHalf(h);
    check(h == 2, "R6 default ratio in effect", h, 2);
    defaultCfg = '0;
    idle(2);
    seen = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge mclk);
      if (sclk || lrclk) seen++;
    end
    check(seen == 0, "R6 register enable ignored when default in use", seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    testReset();
    testDisabled();
    testStartRising();
    testFallDiv4();
    testBadCodeAndBoundary();
    testStopRunning();
    testDefaultPath();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule